// File: doc/BRIEF.md
# Serial Transmit Character Shifter

This block is the transmit half of a synchronous serial channel. A processor writes an 8-bit control word and then data bytes into a single holding register. On each transmit-clock enable pulse the block moves one bit of the current character onto the serial line, least significant bit first. Characters can be eight, seven, six, or one to five bits long. In the short-character mode each byte carries a leading marker in its upper bits, and that marker sets how many low-order data bits are valid.

The control word also drives an active-low terminal-ready pin and a send-break request. While break is active, the line is forced low from the next transmit-clock pulse on, even in the middle of a character. When the channel runs in monosync-with-loop operation and the receiver reports character sync, the break request clears itself. When the transmitter is disabled or no byte is waiting, the line rests at mark (1).

The shifter is a two-state machine. **IDLE** drives mark. **IDLE→SHIFT** (load) happens on a clock pulse while the transmitter is enabled and a byte is waiting. In **SHIFT** the current bit is on the line, and a clock pulse moves to the next bit. **SHIFT→SHIFT** (chained load) happens on the pulse that ends a character when another byte is waiting. **SHIFT→IDLE** (drain) happens on that same pulse when no byte is waiting.

Top module: `tx_char_shifter`

## Requirements
- R1: The control word fields are as follows. Bit 7 is terminal ready. Bits 6:5 are the length code: 00 = one to five bits, 01 = seven, 10 = six, 11 = eight. Bit 4 is break. Bit 3 is transmit enable. Bits 2:0 have no effect on any output.
- R2: A character of n bits appears on `txd` one bit per `bit_tick` pulse, least significant bit first. The first bit appears after the loading pulse. Bits above n are never sent. After exactly n bits the line returns to 1 unless another byte is waiting.
- R3: In the one-to-five mode the length comes from the byte. 1111_000x sends 1 bit, 1110_00xx sends 2, 1100_0xxx sends 3, and 1000_xxxx sends 4. Every other byte, including 000x_xxxx, sends 5.
- R4: A waiting byte is never loaded while transmit enable is 0. With nothing being shifted and break inactive, `txd` is 1.
- R5: Setting break forces `txd` to 0 from the next `bit_tick` onward, whatever the enable. Clearing break hands the line back to the shifter on the next `bit_tick`.
- R6: While `loop_sync_mode` and `rx_char_sync` are both high, the break bit is cleared on the next clock, overriding a control write in the same cycle. `rx_char_sync` alone does nothing.
- R7: `term_ready_n` is the inverse of control bit 7 while `req_pin_mode` is 0, and is held at 1 while `req_pin_mode` is 1.
- R8: A data write lowers `buf_empty` on the next clock. `buf_empty` rises on the `bit_tick` that loads the byte into the shifter.
- R9: Both `rst_n` low and a `chan_reset` pulse clear the control word and the shifter, leaving `txd`=1, `buf_empty`=1 and `term_ready_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| chan_reset | input | 1 | Synchronous channel reset pulse |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word value |
| data_we | input | 1 | Data byte write strobe |
| data_wdata | input | 8 | Data byte value |
| buf_empty | output | 1 | Holding register is free |
| bit_tick | input | 1 | Transmit clock enable, one bit per pulse |
| txd | output | 1 | Serial data out |
| term_ready_n | output | 1 | Terminal-ready pin, active low |
| req_pin_mode | input | 1 | Terminal-ready pin is used as a request pin |
| loop_sync_mode | input | 1 | Monosync-with-loop operation selected |
| rx_char_sync | input | 1 | Receiver reports character sync |

## Verification
The assertions take three things for granted about the inputs. `bit_tick` is a single-cycle pulse. Every strobe is synchronous to `clk`. `req_pin_mode` does not change in the cycle that follows a control write, because the terminal-ready property compares against the written bit one clock later. The bench drives every input on the falling clock edge. It leaves at least one idle cycle between pulses and changes mode pins only between control writes. It loads a byte only while the line is idle, and it sweeps all 256 byte values under each of the four length codes.

// File: rtl/tx_shift_pkg.sv
package tx_shift_pkg;
    localparam int DATA_W   = 8;
    localparam int CHAR_MAX = 8;
    localparam int CNT_W    = $clog2(CHAR_MAX + 1);

    typedef enum logic [1:0] {
        LEN_SHORT = 2'b00,
        LEN_SEVEN = 2'b01,
        LEN_SIX   = 2'b10,
        LEN_EIGHT = 2'b11
    } len_code_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic      term_rdy;
        len_code_e len;
        logic      brk;
        logic      tx_en;
    } tx_ctrl_t;
endpackage

// File: rtl/tx_ctrl_reg.sv
module tx_ctrl_reg
    import tx_shift_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_reset,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              loop_sync_mode,
    input  logic              rx_char_sync,
    output tx_ctrl_t          ctrl
);
    logic unused_cfg_low;
    assign unused_cfg_low = ^cfg_wdata[2:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (chan_reset) begin
            ctrl <= '0;
        end else begin
            if (cfg_we) begin
                ctrl.term_rdy <= cfg_wdata[7];
                ctrl.len      <= len_code_e'(cfg_wdata[6:5]);
                ctrl.brk      <= cfg_wdata[4];
                ctrl.tx_en    <= cfg_wdata[3];
            end
            if (loop_sync_mode && rx_char_sync) begin
                ctrl.brk <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tx_len_decode.sv
module tx_len_decode
    import tx_shift_pkg::*;
(
    input  len_code_e         code,
    input  logic [DATA_W-1:0] char_byte,
    output logic [CNT_W-1:0]  nbits
);
    always_comb begin
        unique case (code)
            LEN_EIGHT: nbits = CNT_W'(8);
            LEN_SEVEN: nbits = CNT_W'(7);
            LEN_SIX:   nbits = CNT_W'(6);
            LEN_SHORT: begin
                if (char_byte[7:1] == 7'b1111000)     nbits = CNT_W'(1);
                else if (char_byte[7:2] == 6'b111000) nbits = CNT_W'(2);
                else if (char_byte[7:3] == 5'b11000)  nbits = CNT_W'(3);
                else if (char_byte[7:4] == 4'b1000)   nbits = CNT_W'(4);
                else                                  nbits = CNT_W'(5);
            end
            default:   nbits = CNT_W'(8);
        endcase
    end
endmodule

// File: rtl/tx_char_shifter.sv
module tx_char_shifter
    import tx_shift_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_reset,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_wdata,
    output logic              buf_empty,
    input  logic              bit_tick,
    output logic              txd,
    output logic              term_ready_n,
    input  logic              req_pin_mode,
    input  logic              loop_sync_mode,
    input  logic              rx_char_sync
);
    tx_ctrl_t          ctrl_q;
    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] hold_q, sh_q;
    logic [CNT_W-1:0]  cnt_q, nbits;
    logic              empty_q, brk_on_q;
    logic              start, last, load;

    tx_ctrl_reg u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .chan_reset     (chan_reset),
        .cfg_we         (cfg_we),
        .cfg_wdata      (cfg_wdata),
        .loop_sync_mode (loop_sync_mode),
        .rx_char_sync   (rx_char_sync),
        .ctrl           (ctrl_q)
    );

    tx_len_decode u_len (
        .code      (ctrl_q.len),
        .char_byte (hold_q),
        .nbits     (nbits)
    );

    assign start = bit_tick && ctrl_q.tx_en && !empty_q;
    assign last  = (cnt_q == CNT_W'(1));
    assign load  = start && ((state_q == ST_IDLE) || last);

    // next-state logic: load, chained load, drain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_SHIFT;
            ST_SHIFT: if (bit_tick && last && !start) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          state_q <= ST_IDLE;
        else if (chan_reset) state_q <= ST_IDLE;
        else                 state_q <= state_d;
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q     <= '0;
            cnt_q    <= '0;
            hold_q   <= '0;
            empty_q  <= 1'b1;
            brk_on_q <= 1'b0;
        end else if (chan_reset) begin
            sh_q     <= '0;
            cnt_q    <= '0;
            hold_q   <= '0;
            empty_q  <= 1'b1;
            brk_on_q <= 1'b0;
        end else begin
            if (load) begin
                sh_q  <= hold_q;
                cnt_q <= nbits;
            end else if ((state_q == ST_SHIFT) && bit_tick) begin
                sh_q  <= sh_q >> 1;
                cnt_q <= cnt_q - CNT_W'(1);
            end
            if (data_we) begin
                hold_q  <= data_wdata;
                empty_q <= 1'b0;
            end else if (load) begin
                empty_q <= 1'b1;
            end
            if (bit_tick) brk_on_q <= ctrl_q.brk;
        end
    end

    assign txd          = brk_on_q ? 1'b0 : ((state_q == ST_SHIFT) ? sh_q[0] : 1'b1);
    assign buf_empty    = empty_q;
    assign term_ready_n = req_pin_mode ? 1'b1 : !ctrl_q.term_rdy;
endmodule

// File: rtl/tx_char_shifter_chk.sv
module tx_char_shifter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       chan_reset,
    input logic       cfg_we,
    input logic [7:0] cfg_wdata,
    input logic       data_we,
    input logic       bit_tick,
    input logic       txd,
    input logic       buf_empty,
    input logic       term_ready_n,
    input logic       req_pin_mode,
    input logic       loop_sync_mode,
    input logic       rx_char_sync,
    input logic       brk
);
    p_brk_tick_r5: assert property (@(posedge clk) disable iff (!rst_n || chan_reset)
        (bit_tick && brk) |=> !txd);

    p_brk_autoclr_r6: assert property (@(posedge clk) disable iff (!rst_n || chan_reset)
        (loop_sync_mode && rx_char_sync) |=> !brk);

    p_term_pin_r7: assert property (@(posedge clk) disable iff (!rst_n || chan_reset)
        cfg_we |=> (req_pin_mode || (term_ready_n == !$past(cfg_wdata[7]))));

    p_hold_fill_r8: assert property (@(posedge clk) disable iff (!rst_n || chan_reset)
        data_we |=> !buf_empty);

    p_hold_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_empty) |-> ($past(bit_tick) || $past(chan_reset)));
endmodule

bind tx_char_shifter tx_char_shifter_chk i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .chan_reset     (chan_reset),
    .cfg_we         (cfg_we),
    .cfg_wdata      (cfg_wdata),
    .data_we        (data_we),
    .bit_tick       (bit_tick),
    .txd            (txd),
    .buf_empty      (buf_empty),
    .term_ready_n   (term_ready_n),
    .req_pin_mode   (req_pin_mode),
    .loop_sync_mode (loop_sync_mode),
    .rx_char_sync   (rx_char_sync),
    .brk            (ctrl_q.brk)
);

// File: tb/test_tx_char_shifter.sv
module test_tx_char_shifter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chan_reset = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       data_we = 1'b0;
    logic [7:0] data_wdata = '0;
    logic       buf_empty;
    logic       bit_tick = 1'b0;
    logic       txd;
    logic       term_ready_n;
    logic       req_pin_mode = 1'b0;
    logic       loop_sync_mode = 1'b0;
    logic       rx_char_sync = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tx_char_shifter i_tx_char_shifter (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        @(negedge clk) begin cfg_we = 1'b1; cfg_wdata = v; end
        @(negedge clk) cfg_we = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] v);
        @(negedge clk) begin data_we = 1'b1; data_wdata = v; end
        @(negedge clk) data_we = 1'b0;
    endtask

    function automatic int exp_len(input int code, input logic [7:0] b);
        if (code == 3) return 8;
        if (code == 1) return 7;
        if (code == 2) return 6;
        for (int n = 1; n <= 4; n++)
            if ((int'(b) >> n) == (((1 << (5 - n)) - 1) << 3)) return n;
        return 5;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(txd == 1'b1, "R9 reset txd", txd, 1);
        check(buf_empty == 1'b1, "R9 reset buf_empty", buf_empty, 1);
        check(term_ready_n == 1'b1, "R9 reset term_ready_n", term_ready_n, 1);

        // R1 R2 R3 R8: sweep every byte under every length code, bits 2:0 set
        for (int code = 0; code < 4; code++) begin
            wr_cfg({1'b0, 2'(code), 1'b0, 1'b1, 3'b111});
            for (int b = 0; b < 256; b++) begin
                int n;
                n = exp_len(code, 8'(b));
                wr_data(8'(b));
                check(buf_empty == 1'b0, "R8 filled", buf_empty, 0);
                for (int i = 0; i < n; i++) begin
                    tick();
                    if (i == 0) check(buf_empty == 1'b1, "R8 drained on load", buf_empty, 1);
                    check(txd == b[i], (code == 0) ? "R3 short bit" : "R2 bit order", txd, b[i]);
                end
                tick();
                check(txd == 1'b1, "R1 length then idle", txd, 1);
            end
        end

        // R4: disabled transmitter keeps byte waiting, line at mark
        wr_cfg(8'b0_11_0_0_000);
        wr_data(8'h5A);
        for (int i = 0; i < 4; i++) begin
            tick();
            check(txd == 1'b1, "R4 idle when disabled", txd, 1);
        end
        check(buf_empty == 1'b0, "R4 no load when disabled", buf_empty, 0);
        wr_cfg(8'b0_11_0_1_000);
        for (int i = 0; i < 8; i++) begin
            tick();
            check(txd == ((8'h5A >> i) & 1), "R4 sends after enable", txd, (8'h5A >> i) & 1);
        end
        tick();
        check(txd == 1'b1, "R4 idle after char", txd, 1);

        // R5: break mid-character
        wr_data(8'hFF);
        tick();
        tick();
        wr_cfg(8'b0_11_1_1_000);
        check(txd == 1'b1, "R5 no force before tick", txd, 1);
        tick();
        check(txd == 1'b0, "R5 forced on next tick", txd, 0);
        tick();
        check(txd == 1'b0, "R5 stays forced", txd, 0);
        wr_cfg(8'b0_11_0_1_000);
        check(txd == 1'b0, "R5 held until tick", txd, 0);
        tick();
        check(txd == 1'b1, "R5 released", txd, 1);
        for (int i = 0; i < 6; i++) tick();
        check(txd == 1'b1, "R5 idle after release", txd, 1);

        // R5: break with transmitter disabled
        wr_cfg(8'b0_11_1_0_000);
        tick();
        check(txd == 1'b0, "R5 break while disabled", txd, 0);

        // R6: sync alone does nothing, loop + sync clears break
        @(negedge clk) rx_char_sync = 1'b1;
        @(negedge clk) rx_char_sync = 1'b0;
        tick();
        check(txd == 1'b0, "R6 sync without loop", txd, 0);
        @(negedge clk) begin loop_sync_mode = 1'b1; rx_char_sync = 1'b1; end
        @(negedge clk) begin loop_sync_mode = 1'b0; rx_char_sync = 1'b0; end
        tick();
        check(txd == 1'b1, "R6 break self-cleared", txd, 1);
        // R6: auto-clear wins over a same-cycle write
        @(negedge clk) begin
            loop_sync_mode = 1'b1; rx_char_sync = 1'b1;
            cfg_we = 1'b1; cfg_wdata = 8'b0_11_1_0_000;
        end
        @(negedge clk) begin loop_sync_mode = 1'b0; rx_char_sync = 1'b0; cfg_we = 1'b0; end
        tick();
        check(txd == 1'b1, "R6 clear beats write", txd, 1);

        // R7: terminal-ready pin
        wr_cfg(8'b1_11_0_0_000);
        check(term_ready_n == 1'b0, "R7 bit7 set", term_ready_n, 0);
        @(negedge clk) req_pin_mode = 1'b1;
        @(negedge clk);
        check(term_ready_n == 1'b1, "R7 request mode", term_ready_n, 1);
        @(negedge clk) req_pin_mode = 1'b0;
        @(negedge clk);
        check(term_ready_n == 1'b0, "R7 back to ready", term_ready_n, 0);
        wr_cfg(8'b0_11_0_0_000);
        check(term_ready_n == 1'b1, "R7 bit7 clear", term_ready_n, 1);

        // R9: channel reset
        wr_cfg(8'b1_11_1_0_000);
        wr_data(8'h33);
        tick();
        check(txd == 1'b0, "R9 break before chan reset", txd, 0);
        @(negedge clk) chan_reset = 1'b1;
        @(negedge clk) chan_reset = 1'b0;
        check(term_ready_n == 1'b1, "R9 chan reset term", term_ready_n, 1);
        check(buf_empty == 1'b1, "R9 chan reset buf", buf_empty, 1);
        tick();
        check(txd == 1'b1, "R9 chan reset break", txd, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule